// File: doc/BRIEF.md
# Comma Word Aligner

The aligner sits behind a deserializer whose parallel word boundary is arbitrary. Each clock it receives one 10-bit raw word and keeps the previous raw word. It scans every bit offset of the combined 20 bits for the 8B/10B comma, and a barrel shifter re-frames the stream so that each output word starts on a true code-group boundary. The comma patterns are parameters. Both running-disparity forms of K28.5 are the default, and any other pattern can be set in their place.

The aligner has two ways to find the boundary. In automatic mode, with the enable input high, a detected comma may move the boundary. In manual mode the boundary moves only when a bit-slip is requested, one bit per request, and no alignment characters are needed. A detect flag marks each output word that is a comma. A sync flag reports whether the current boundary was found from a comma.

Top module: `comma_word_aligner`

## Requirements
- R1: While `rst_ni` is low, `data_o`, `comma_o` and `sync_o` are 0, and the boundary offset is 0.
- R2: Bit 0 of `raw_i` is the earliest received bit. The default comma forms are 0x17C and 0x283 in this bit order, and each form is recognised.
- R3: With `align_en_i` high, a comma that starts at any offset from 0 to 9 of {current raw, previous raw} appears whole on `data_o` one edge after the later word is presented. Every following output word is then the next code group.
- R4: `comma_o` is high exactly while `data_o` holds a comma form. This holds whatever the states of `sync_o` and `align_en_i`.
- R5: `sync_o` goes high on the edge that outputs the first comma found with `align_en_i` high. It stays 0 while no comma has been found in that mode.
- R6: While `align_en_i` is low, commas at other offsets do not move the boundary, and `sync_o` does not rise.
- R7: With offset k, the output word is bits k to k+9 of {current raw, previous raw}. Each cycle with `slip_i` high adds one to k, and the change shows on the next output word. An offset of 9 wraps to 0.
- R8: `slip_i` clears `sync_o`. It also takes precedence over a comma detected in the same cycle.
- R9: A comma at the current offset keeps the boundary. When a comma is found elsewhere, the lowest matching offset is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 10 | Unaligned raw word, bit 0 earliest |
| align_en_i | input | 1 | Allows a detected comma to move the boundary |
| slip_i | input | 1 | Shifts the boundary by one bit per cycle high |
| data_o | output | 10 | Aligned word |
| comma_o | output | 1 | Output word is a comma |
| sync_o | output | 1 | Boundary was found from a comma |

## Verification
`data_o` and `comma_o` are registered. They carry the window of the word presented before an edge one edge later, and a newly found comma is already framed in that same output. `sync_o` and the offset update on that same edge. A slip shows only on the output word after it, because the word at the slip edge still uses the old offset. The bench drives inputs on the falling edge and samples 1 ns after the rising edge. It rebuilds the serial stream from the code groups and the injected shift, and for each output word computes the expected value for the offset that is due at that edge.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  // comma forms, bit 0 = first received bit
  localparam logic [9:0] K28_5_RDN = 10'h17C;
  localparam logic [9:0] K28_5_RDP = 10'h283;
endpackage

// File: rtl/cwa_pattern_scan.sv
module cwa_pattern_scan #(
  parameter int W = 10,
  parameter logic [W-1:0] PAT_A = '0,
  parameter logic [W-1:0] PAT_B = '0,
  localparam int SW = 2 * W
) (
  input  logic [SW-1:0] stream_i,
  output logic [W-1:0]  hit_o
);
  for (genvar k = 0; k < W; k++) begin : g_off
    logic [W-1:0] win;
    assign win = stream_i[k +: W];
    assign hit_o[k] = (win == PAT_A) || (win == PAT_B);
  end
endmodule

// File: rtl/cwa_barrel_shift.sv
module cwa_barrel_shift #(
  parameter int W = 10,
  localparam int SW = 2 * W,
  localparam int OFF_W = $clog2(W)
) (
  input  logic [SW-1:0]    stream_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [W-1:0]     win_o
);
  logic [W-1:0] wins [W];

  for (genvar k = 0; k < W; k++) begin : g_win
    assign wins[k] = stream_i[k +: W];
  end

  always_comb begin
    win_o = '0;
    for (int k = 0; k < W; k++) begin
      if (off_i == OFF_W'(k)) win_o = wins[k];
    end
  end
endmodule

// File: rtl/cwa_boundary_ctrl.sv
module cwa_boundary_ctrl #(
  parameter int W = 10,
  localparam int OFF_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slip_i,
  input  logic             align_en_i,
  input  logic [W-1:0]     hit_i,
  output logic [OFF_W-1:0] sel_off_o,
  output logic [OFF_W-1:0] off_o,
  output logic             sync_o
);
  logic [OFF_W-1:0] off_q, first_off, slip_off;
  logic             sync_q, any_hit, cur_hit, move;

  // lowest matching offset wins
  always_comb begin
    first_off = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit_i[k]) first_off = OFF_W'(k);
    end
  end

  always_comb begin
    cur_hit = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (off_q == OFF_W'(k)) cur_hit = hit_i[k];
    end
  end

  assign any_hit   = |hit_i;
  assign move      = align_en_i & ~slip_i & any_hit & ~cur_hit;
  assign sel_off_o = move ? first_off : off_q;
  assign slip_off  = (off_q == OFF_W'(W - 1)) ? '0 : off_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      sync_q <= 1'b0;
    end else if (slip_i) begin
      off_q  <= slip_off;
      sync_q <= 1'b0;
    end else begin
      off_q <= sel_off_o;
      if (align_en_i && any_hit) sync_q <= 1'b1;
    end
  end

  assign off_o  = off_q;
  assign sync_o = sync_q;
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int W = 10,
  parameter logic [W-1:0] PAT_A = cwa_pkg::K28_5_RDN,
  parameter logic [W-1:0] PAT_B = cwa_pkg::K28_5_RDP,
  localparam int SW = 2 * W,
  localparam int OFF_W = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic         align_en_i,
  input  logic         slip_i,
  output logic [W-1:0] data_o,
  output logic         comma_o,
  output logic         sync_o
);
  logic [W-1:0]     prev_q, win, hit;
  logic [SW-1:0]    stream;
  logic [OFF_W-1:0] sel_off, off_q;
  logic             sel_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= raw_i;
  end

  // earlier word in the low half
  assign stream = {raw_i, prev_q};

  cwa_pattern_scan #(.W(W), .PAT_A(PAT_A), .PAT_B(PAT_B)) u_scan (
    .stream_i (stream),
    .hit_o    (hit)
  );

  cwa_boundary_ctrl #(.W(W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slip_i     (slip_i),
    .align_en_i (align_en_i),
    .hit_i      (hit),
    .sel_off_o  (sel_off),
    .off_o      (off_q),
    .sync_o     (sync_o)
  );

  cwa_barrel_shift #(.W(W)) u_shift (
    .stream_i (stream),
    .off_i    (sel_off),
    .win_o    (win)
  );

  always_comb begin
    sel_hit = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (sel_off == OFF_W'(k)) sel_hit = hit[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      comma_o <= 1'b0;
    end else begin
      data_o  <= win;
      comma_o <= sel_hit;
    end
  end
endmodule

// File: rtl/cwa_checker.sv
module cwa_checker #(
  parameter int W = 10,
  parameter logic [W-1:0] PAT_A = '0,
  parameter logic [W-1:0] PAT_B = '0,
  localparam int OFF_W = $clog2(W)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             align_en_i,
  input logic             slip_i,
  input logic [W-1:0]     data_o,
  input logic             comma_o,
  input logic             sync_o,
  input logic [OFF_W-1:0] off_q
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!sync_o && !comma_o && data_o == '0 && off_q == '0));

  a_r4_flag_matches_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comma_o |-> (data_o == PAT_A || data_o == PAT_B));

  a_r5_sync_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(align_en_i));

  a_r6_manual_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!align_en_i && !slip_i) |=> $stable(off_q));

  a_r7_offset_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q < OFF_W'(W));

  a_r7_slip_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_i |=> off_q == (($past(off_q) == OFF_W'(W - 1)) ? '0 : $past(off_q) + 1'b1));

  a_r8_slip_drops_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_i |=> !sync_o);
endmodule

bind comma_word_aligner cwa_checker #(.W(W), .PAT_A(PAT_A), .PAT_B(PAT_B)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .align_en_i (align_en_i),
  .slip_i     (slip_i),
  .data_o     (data_o),
  .comma_o    (comma_o),
  .sync_o     (sync_o),
  .off_q      (off_q)
);

// File: tb/comma_word_aligner_bench.sv
`timescale 1ns/1ps
module comma_word_aligner_bench;
  localparam logic [9:0] CA = 10'h17C;
  localparam logic [9:0] CB = 10'h283;
  localparam logic [9:0] FILL = 10'h155;
  // {enable, shift}
  localparam logic [4:0] VEC [0:11] = '{
    5'h10, 5'h11, 5'h13, 5'h15, 5'h17, 5'h19,
    5'h12, 5'h18, 5'h04, 5'h09, 5'h06, 5'h00
  };

  logic clk = 1'b0, rst_ni = 1'b0, align_en_i = 1'b0, slip_i = 1'b0;
  logic [9:0] raw_i = '0, data_o;
  logic comma_o, sync_o;
  int n_chk = 0, n_err = 0, t = 0, cur_s = 0;

  always #2.5 clk = ~clk;

  comma_word_aligner u_comma_word_aligner (
    .clk_i(clk), .rst_ni(rst_ni), .raw_i(raw_i), .align_en_i(align_en_i),
    .slip_i(slip_i), .data_o(data_o), .comma_o(comma_o), .sync_o(sync_o)
  );

  function automatic logic [9:0] grp(int j);
    if (j % 8 == 3) return ((j / 8) % 2 == 0) ? CA : CB;
    return FILL;
  endfunction

  function automatic logic bitv(int n);
    logic [9:0] g;
    if (n < cur_s) return n[0];
    g = grp((n - cur_s) / 10);
    return g[(n - cur_s) % 10];
  endfunction

  function automatic logic [9:0] word(int tt);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[i] = bitv(10 * tt + i);
    return w;
  endfunction

  function automatic logic [9:0] win(int tt, int off);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[i] = bitv(10 * (tt - 1) + off + i);
    return w;
  endfunction

  function automatic logic is_comma(logic [9:0] v);
    return v == CA || v == CB;
  endfunction

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s t=%0d actual=%h expected=%h", req, t, act, exp);
    end
  endtask

  task automatic do_reset(int s);
    @(negedge clk);
    rst_ni = 1'b0; raw_i = '0; slip_i = 1'b0; align_en_i = 1'b0; cur_s = s;
    repeat (2) @(negedge clk);
    check("R1 data", data_o, '0);
    check("R1 comma", {9'd0, comma_o}, 10'd0);
    check("R1 sync", {9'd0, sync_o}, 10'd0);
    rst_ni = 1'b1;
    t = 0;
  endtask

  // drive word t, wait for edge, leave t pointing at the word just applied
  task automatic step(logic sl, logic en);
    @(negedge clk);
    raw_i = word(t); slip_i = sl; align_en_i = en;
    @(posedge clk);
    #1;
  endtask

  task automatic adv();
    t++;
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    // table: R2 R3 R4 R5 automatic, R6 gated
    foreach (VEC[v]) begin
      do_reset(int'(VEC[v][3:0]));
      for (int c = 0; c < 40; c++) begin
        step(1'b0, VEC[v][4]);
        if (VEC[v][4]) begin
          if (t >= 4) begin
            check("R3 aligned word", data_o, grp(t - 1));
            check("R4 detect", {9'd0, comma_o}, {9'd0, is_comma(grp(t - 1))});
            check("R5 sync high", {9'd0, sync_o}, 10'd1);
          end else begin
            check("R5 sync low before comma", {9'd0, sync_o}, 10'd0);
          end
        end else if (t >= 1) begin
          check("R6 boundary held", data_o, win(t, 0));
          check("R6 sync low", {9'd0, sync_o}, 10'd0);
        end
        adv();
      end
    end

    // R7: ten slips wrap the offset back to 0
    do_reset(0);
    for (int c = 0; c < 12; c++) begin step(1'b0, 1'b0); adv(); end
    for (int n = 1; n <= 10; n++) begin
      step(1'b1, 1'b0);
      check("R7 slip old offset", data_o, win(t, n - 1));
      adv();
    end
    step(1'b0, 1'b0);
    check("R7 wrap to 0", data_o, win(t, 0));
    adv();

    // R8: slip beats a comma at the same cycle, clears sync
    do_reset(3);
    for (int c = 0; c < 20; c++) begin step(1'b0, 1'b1); adv(); end
    step(1'b1, 1'b1);
    check("R8 slip cycle word", data_o, grp(t - 1));
    check("R8 sync cleared", {9'd0, sync_o}, 10'd0);
    adv();
    step(1'b0, 1'b1);
    check("R7 offset after slip", data_o, win(t, 4));
    check("R8 sync stays low", {9'd0, sync_o}, 10'd0);
    adv();
    while (t < 28) begin step(1'b0, 1'b1); adv(); end
    step(1'b0, 1'b1);
    check("R9 realign to lowest hit", data_o, grp(t - 1));
    check("R3 comma out", {9'd0, comma_o}, 10'd1);
    check("R5 sync regained", {9'd0, sync_o}, 10'd1);
    adv();

    // R4 R6: manual alignment by slips, detect without sync
    do_reset(2);
    for (int c = 0; c < 6; c++) begin
      step(1'b0, 1'b0);
      if (t == 4) begin
        check("R6 comma ignored", data_o, win(t, 0));
        check("R6 no detect", {9'd0, comma_o}, 10'd0);
      end
      adv();
    end
    step(1'b1, 1'b0); adv();
    step(1'b1, 1'b0); adv();
    while (t <= 40) begin
      step(1'b0, 1'b0);
      check("R7 manual aligned", data_o, grp(t - 1));
      check("R4 detect manual", {9'd0, comma_o}, {9'd0, is_comma(grp(t - 1))});
      check("R6 sync low manual", {9'd0, sync_o}, 10'd0);
      adv();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule